// File: doc/BRIEF.md
# Legacy Display Address Forwarding Decoder

This block sits in the downstream path of a bridge and judges each access that arrives on the primary side. It works on memory and I/O accesses. It tells whether the access must be passed to the secondary interface. It also tells whether the same address must be kept from crossing in the upstream direction. The legacy display ranges are decoded inside the block:

- memory from 0x000A_0000 to 0x000B_FFFF;
- the two small I/O windows in the lowest 64 KB of I/O space, with or without their ISA aliases.

The normal base/limit window result arrives as the single input `win_hit`. Any ISA filtering has already been applied to that result.

When the display enable is set, a display-range hit forwards even when the window result is low. It still needs the command-register enable for its access type. When the display enable is clear, only the window result can cause forwarding. A two-state machine registers the verdict. `ST_IDLE` means no verdict is presented. `ST_RESULT` means a verdict from the previous cycle is on the outputs.

The state machine has these transitions:
- `ST_IDLE` to `ST_RESULT` on a request strobe.
- `ST_RESULT` to `ST_RESULT` on a back-to-back strobe.
- `ST_RESULT` to `ST_IDLE` when no strobe is present.

Reset places the machine in `ST_IDLE`.

Top module: `vga_fwd_decoder`

## Requirements
- R1: `fwd_valid` is 1 in the cycle after a clock edge that samples `req_valid`=1, and 0 after an edge that samples `req_valid`=0. While `fwd_valid` is 0, `fwd_down` and `up_block` are 0.
- R2: A memory access (`req_is_io`=0) is a display hit exactly when its address lies in 0x000A_0000..0x000B_FFFF inclusive.
- R3: An I/O access (`req_is_io`=1) can be a display hit only when address bits [31:16] are zero and bits [9:0] lie in 0x3B0..0x3BB or 0x3C0..0x3DF.
- R4: With `cfg_dec16`=0, address bits [15:10] play no part in the I/O hit, so aliases of the windows also hit.
- R5: With `cfg_dec16`=1, an I/O hit additionally needs address bits [15:10] to be zero.
- R6: With `cfg_disp_en`=1 and the command enable for the access type set, a display hit forwards whatever the value of `win_hit`.
- R7: I/O accesses forward only with `cmd_io_en`=1, and memory accesses forward only with `cmd_mem_en`=1. This applies to display hits and to window hits alike.
- R8: With `cfg_disp_en`=0, an access forwards exactly when `win_hit`=1 and its command enable is set.
- R9: `up_block` equals `cfg_disp_en` AND display hit for the sampled access. It does not depend on the command enables or on `win_hit`.
- R10: After reset, `fwd_valid`, `fwd_down` and `up_block` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe; inputs are sampled when it is 1 |
| req_addr | input | ADDR_W (32) | Access address |
| req_is_io | input | 1 | 1 = I/O access, 0 = memory access |
| cfg_disp_en | input | 1 | Legacy display range forwarding enable |
| cfg_dec16 | input | 1 | Full 16-bit I/O decode select |
| cmd_io_en | input | 1 | Command register I/O enable |
| cmd_mem_en | input | 1 | Command register memory enable |
| win_hit | input | 1 | Result of the external base/limit and ISA decode |
| fwd_valid | output | 1 | A verdict is presented this cycle |
| fwd_down | output | 1 | Forward the access to the secondary interface |
| up_block | output | 1 | Block this address range in the upstream direction |

## Verification
Two decisions can fall in the same cycle: the display-range override and the window decode. A second pair is the downstream forward and the upstream block. Both overlaps are provoked by sweeping every combination of the five configuration and window bits against every I/O offset in the 10-bit space, with varied alias bits and occasional nonzero upper bits. Memory addresses just inside and just outside both range edges are swept the same way. Each sampled verdict is compared with an arithmetic model. The comparison checks that `fwd_down` and `up_block` separate correctly: the block flag follows the display hit even when the command enable suppresses forwarding.

// File: rtl/vga_fwd_pkg.sv
package vga_fwd_pkg;

    localparam logic [31:0] DISP_MEM_LO = 32'h000A_0000;
    localparam logic [31:0] DISP_MEM_HI = 32'h000B_FFFF;

    localparam logic [9:0] DISP_IO_A_LO = 10'h3B0;
    localparam logic [9:0] DISP_IO_A_HI = 10'h3BB;
    localparam logic [9:0] DISP_IO_B_LO = 10'h3C0;
    localparam logic [9:0] DISP_IO_B_HI = 10'h3DF;

    localparam int IO_ALIAS_LSB = 10;
    localparam int IO_SPACE_LSB = 16;

    typedef enum logic [0:0] {
        ST_IDLE   = 1'b0,
        ST_RESULT = 1'b1
    } fwd_state_e;

    typedef struct packed {
        logic fwd;
        logic blk;
    } verdict_t;

endpackage

// File: rtl/vga_mem_match.sv
module vga_mem_match
    import vga_fwd_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              is_io,
    output logic              hit
);
    localparam logic [ADDR_W-1:0] LO = ADDR_W'(DISP_MEM_LO);
    localparam logic [ADDR_W-1:0] HI = ADDR_W'(DISP_MEM_HI);

    always_comb begin
        hit = !is_io && (addr >= LO) && (addr <= HI);
    end
endmodule

// File: rtl/vga_io_match.sv
module vga_io_match
    import vga_fwd_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              is_io,
    input  logic              dec16,
    output logic              hit
);
    localparam int ALIAS_W = IO_SPACE_LSB - IO_ALIAS_LSB;

    logic [9:0]         offs;
    logic [ALIAS_W-1:0] alias_bits;
    logic               upper_zero;
    logic               in_win;

    always_comb begin
        offs       = addr[IO_ALIAS_LSB-1:0];
        alias_bits = addr[IO_SPACE_LSB-1:IO_ALIAS_LSB];
        upper_zero = (addr[ADDR_W-1:IO_SPACE_LSB] == '0);
        in_win     = ((offs >= DISP_IO_A_LO) && (offs <= DISP_IO_A_HI)) ||
                     ((offs >= DISP_IO_B_LO) && (offs <= DISP_IO_B_HI));
        hit        = is_io && upper_zero && in_win &&
                     (!dec16 || (alias_bits == '0));
    end
endmodule

// File: rtl/vga_fwd_decoder.sv
module vga_fwd_decoder
    import vga_fwd_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_is_io,
    input  logic              cfg_disp_en,
    input  logic              cfg_dec16,
    input  logic              cmd_io_en,
    input  logic              cmd_mem_en,
    input  logic              win_hit,
    output logic              fwd_valid,
    output logic              fwd_down,
    output logic              up_block
);
    fwd_state_e state_q, state_d;
    verdict_t   verdict_q, verdict_d;

    logic mem_hit, io_hit, disp_hit, type_en;

    vga_mem_match #(.ADDR_W(ADDR_W)) u_mem (
        .addr  (req_addr),
        .is_io (req_is_io),
        .hit   (mem_hit)
    );

    vga_io_match #(.ADDR_W(ADDR_W)) u_io (
        .addr  (req_addr),
        .is_io (req_is_io),
        .dec16 (cfg_dec16),
        .hit   (io_hit)
    );

    always_comb begin
        disp_hit      = mem_hit || io_hit;
        type_en       = req_is_io ? cmd_io_en : cmd_mem_en;
        verdict_d.fwd = type_en && ((cfg_disp_en && disp_hit) || win_hit);
        verdict_d.blk = cfg_disp_en && disp_hit;
        state_d       = req_valid ? ST_RESULT : ST_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            verdict_q <= '0;
        end else begin
            state_q <= state_d;
            if (req_valid) begin
                verdict_q <= verdict_d;
            end
        end
    end

    always_comb begin
        fwd_valid = 1'b0;
        fwd_down  = 1'b0;
        up_block  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                fwd_valid = 1'b0;
            end
            ST_RESULT: begin
                fwd_valid = 1'b1;
                fwd_down  = verdict_q.fwd;
                up_block  = verdict_q.blk;
            end
            default: begin
                fwd_valid = 1'b0;
            end
        endcase
    end

    assert_valid_follows_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> fwd_valid);
    assert_idle_after_gap_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !fwd_valid);
    assert_quiet_when_invalid_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_down || up_block) |-> fwd_valid);
    assert_window_forwards_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && win_hit && ((req_is_io && cmd_io_en) || (!req_is_io && cmd_mem_en)))
        |=> fwd_down);
    assert_io_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_is_io && !cmd_io_en) |=> !fwd_down);
    assert_mem_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_is_io && !cmd_mem_en) |=> !fwd_down);
    assert_window_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !cfg_disp_en && !win_hit) |=> !fwd_down);
    assert_no_block_when_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !cfg_disp_en) |=> !up_block);
endmodule

// File: tb/vga_fwd_decoder_bench.sv
`timescale 1ns/1ps
module vga_fwd_decoder_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_is_io = 1'b0;
    logic        cfg_disp_en = 1'b0;
    logic        cfg_dec16 = 1'b0;
    logic        cmd_io_en = 1'b0;
    logic        cmd_mem_en = 1'b0;
    logic        win_hit = 1'b0;
    logic        fwd_valid, fwd_down, up_block;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    vga_fwd_decoder u_vga_fwd_decoder (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_is_io(req_is_io), .cfg_disp_en(cfg_disp_en), .cfg_dec16(cfg_dec16),
        .cmd_io_en(cmd_io_en), .cmd_mem_en(cmd_mem_en), .win_hit(win_hit),
        .fwd_valid(fwd_valid), .fwd_down(fwd_down), .up_block(up_block)
    );

    function automatic bit model_hit(logic [31:0] a, bit io, bit d16);
        logic [9:0] lo;
        lo = a[9:0];
        if (io)
            return (a[31:16] == 16'h0) && (!d16 || a[15:10] == 6'h0) &&
                   ((lo >= 10'h3B0 && lo <= 10'h3BB) || (lo >= 10'h3C0 && lo <= 10'h3DF));
        return (a >= 32'h000A_0000) && (a <= 32'h000B_FFFF);
    endfunction

    task automatic check(string tag, logic act, logic exp, logic [31:0] a);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s addr=%h act=%b exp=%b", tag, a, act, exp);
        end
    endtask

    task automatic apply(logic [31:0] a, bit io, int cfg);
        bit en_ok, hit, exp_fwd, exp_blk;
        string ftag;
        req_valid   = 1'b1;
        req_addr    = a;
        req_is_io   = io;
        cfg_disp_en = cfg[0];
        cfg_dec16   = cfg[1];
        cmd_io_en   = cfg[2];
        cmd_mem_en  = cfg[3];
        win_hit     = cfg[4];
        @(posedge clk);
        @(negedge clk);
        hit     = model_hit(a, io, cfg[1]);
        en_ok   = io ? cfg[2] : cfg[3];
        exp_fwd = en_ok && ((cfg[0] && hit) || cfg[4]);
        exp_blk = cfg[0] && hit;
        if (!en_ok)        ftag = "R7";
        else if (!cfg[0])  ftag = "R8";
        else if (cfg[4])   ftag = "R6";
        else if (!io)      ftag = "R2";
        else if (cfg[1])   ftag = "R5";
        else if (a[15:10] != 0) ftag = "R4";
        else               ftag = "R3";
        check("R1", fwd_valid, 1'b1, a);
        check(ftag, fwd_down, exp_fwd, a);
        check("R9", up_block, exp_blk, a);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] mem_pts [10];
        mem_pts = '{32'h0009_FFFF, 32'h000A_0000, 32'h000A_0001, 32'h000B_0000,
                    32'h000B_FFFF, 32'h000C_0000, 32'h0000_0000, 32'h100A_0000,
                    32'h000A_03C0, 32'h0000_03C0};
        repeat (3) @(negedge clk);
        check("R10", fwd_valid, 1'b0, '0);
        check("R10", fwd_down, 1'b0, '0);
        check("R10", up_block, 1'b0, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10", fwd_valid, 1'b0, '0);

        for (int cfg = 0; cfg < 32; cfg++) begin
            for (int lo = 0; lo < 1024; lo++) begin
                logic [31:0] a;
                logic [5:0]  al;
                al = (lo % 2 == 1) ? 6'h0 : 6'((lo * 5 + cfg) & 63);
                a  = {((lo % 17) == 0) ? 16'h0001 : 16'h0000, al, 10'(lo)};
                apply(a, 1'b1, cfg);
            end
            for (int k = 0; k < 10; k++) begin
                apply(mem_pts[k], 1'b0, cfg);
                apply(mem_pts[k], 1'b1, cfg);
            end
        end

        // R1: gap cycle drops the verdict
        apply(32'h000A_0000, 1'b0, 5'b01001);
        req_valid = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R1", fwd_valid, 1'b0, 32'h000A_0000);
        check("R1", fwd_down, 1'b0, 32'h000A_0000);
        check("R1", up_block, 1'b0, 32'h000A_0000);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule